// File: doc/BRIEF.md
# Branch Trace History Store

This block keeps a short history of taken branches reported by a CPU retire stage. Each branch event arrives with a class code and two addresses: where the branch came from and where it went. If the class is enabled and no exclusion rule applies, the event is written into an eight-entry circular store. Each stored entry holds the source, the destination and the class. A debugger reads the entries back by age through a registered read port, where index 0 is the oldest entry.

Two exclusion rules apply to events. A conditional branch with a zero displacement is dropped. A branch into the reset vector that was caused by reset is also dropped. When an exception is of the completion type, the store records the address of the following instruction as the source.

In wrap mode the store keeps only the most recent eight branches. In continuous mode each fill of eight entries raises a drain request toward the debugger. While that request is pending, new events are refused. An acknowledge empties the store so capture can go on. After the fourth acknowledged fill, capture stops until reset.

Top module: `brtrace_buf`

## Requirements
- R1: After a synchronous reset, `fill_cnt` is 0 and both `drain_req` and `cap_done` are 0.
- R2: An event is stored only when the enable for its class is set. The class codes are 0 for normal, 1 for subroutine and 2 for exception. Code 3 is never stored.
- R3: An event flagged as a conditional branch with zero displacement is never stored.
- R4: An event flagged as a reset-caused branch to the reset vector is never stored.
- R5: An exception-class event (code 2) with the completion flag set stores `br_next_pc` as its source. For any other class, the completion flag has no effect.
- R6: In wrap mode, `fill_cnt` counts stored entries and saturates at 8. A ninth and later entry overwrites the oldest one. Read index 0 selects the oldest entry and index 7 the newest.
- R7: The read data for `rd_idx` appears on `rd_src`, `rd_dst` and `rd_class` one clock after `rd_idx` is presented.
- R8: In continuous mode, `drain_req` rises on the clock that stores the eighth entry. While `drain_req` is high, events are not stored.
- R9: `drain_ack` while `drain_req` is high clears `drain_req` and sets `fill_cnt` to 0 on the next clock.
- R10: The acknowledge of the fourth fill sets `cap_done`. From then until reset, no event is stored and `drain_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Retire-stage branch event strobe |
| br_class | input | 2 | Class code: 0 normal, 1 subroutine, 2 exception |
| br_src | input | AW | Branch source address |
| br_dst | input | AW | Branch destination address |
| br_next_pc | input | AW | Address of the instruction after the source |
| br_zero_disp | input | 1 | Conditional branch with zero displacement |
| br_from_reset | input | 1 | Reset-caused branch to the reset vector |
| br_completion | input | 1 | Exception is of completion type |
| en_normal | input | 1 | Store normal-class events |
| en_subr | input | 1 | Store subroutine-class events |
| en_excp | input | 1 | Store exception-class events |
| cont_mode | input | 1 | Continuous mode select (1) or wrap mode (0) |
| drain_ack | input | 1 | Debugger has drained the store |
| rd_idx | input | 3 | Read index, 0 is the oldest entry |
| rd_src | output | AW | Stored source address |
| rd_dst | output | AW | Stored destination address |
| rd_class | output | 2 | Stored class code |
| fill_cnt | output | 4 | Number of valid entries |
| drain_req | output | 1 | Stall/drain request to the debugger |
| cap_done | output | 1 | Continuous capture finished |

## Verification
An event presented in one cycle shows up in `fill_cnt`, `drain_req` and `cap_done` at the next rising edge. The read port adds one more edge between `rd_idx` and the data. The bench drives inputs on the falling edge. It steps a queue-based model on each rising edge and compares the status outputs on every falling edge, so each result is checked half a cycle after the edge that produced it. Each read check holds `rd_idx` for one full cycle with no event in flight, then compares against the model's queue at that index.

// File: rtl/brtrace_pkg.sv
`timescale 1ns/1ps
package brtrace_pkg;
  typedef enum logic [1:0] {
    CLS_NORMAL = 2'd0,
    CLS_SUBR   = 2'd1,
    CLS_EXCP   = 2'd2,
    CLS_NONE   = 2'd3
  } br_cls_e;
endpackage

// File: rtl/brtrace_filter.sv
`timescale 1ns/1ps
module brtrace_filter
  import brtrace_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          br_valid,
  input  logic [1:0]    br_class,
  input  logic [AW-1:0] br_src,
  input  logic [AW-1:0] br_next_pc,
  input  logic          br_zero_disp,
  input  logic          br_from_reset,
  input  logic          br_completion,
  input  logic          en_normal,
  input  logic          en_subr,
  input  logic          en_excp,
  output logic          keep,
  output logic [AW-1:0] src_sel
);
  logic cls_on;

  always_comb begin
    unique case (br_cls_e'(br_class))
      CLS_NORMAL: cls_on = en_normal;
      CLS_SUBR:   cls_on = en_subr;
      CLS_EXCP:   cls_on = en_excp;
      default:    cls_on = 1'b0;
    endcase
  end

  assign keep = br_valid & cls_on & ~br_zero_disp & ~br_from_reset;

  // completion-type exceptions report the following instruction
  assign src_sel = (br_class == CLS_EXCP && br_completion) ? br_next_pc : br_src;
endmodule

// File: rtl/brtrace_ctrl.sv
`timescale 1ns/1ps
module brtrace_ctrl #(
  parameter int DEPTH = 8,
  parameter int FILLS = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int FW = $clog2(FILLS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          keep,
  input  logic          cont_mode,
  input  logic          drain_ack,
  output logic          wr_en,
  output logic [PW-1:0] wptr_q,
  output logic [CW-1:0] count_q,
  output logic          drain_q,
  output logic          cap_done_q
);
  logic [FW-1:0] fills_q;
  logic          hold, last_slot, ack_ok;

  assign hold      = cont_mode & (drain_q | cap_done_q);
  assign wr_en     = keep & ~hold;
  assign last_slot = (count_q == CW'(DEPTH - 1));
  assign ack_ok    = cont_mode & drain_q & drain_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q     <= '0;
      count_q    <= '0;
      drain_q    <= 1'b0;
      cap_done_q <= 1'b0;
      fills_q    <= '0;
    end else begin
      if (wr_en)
        wptr_q <= (wptr_q == PW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (ack_ok)
        count_q <= '0;
      else if (wr_en && count_q != CW'(DEPTH))
        count_q <= count_q + 1'b1;
      if (ack_ok)
        drain_q <= 1'b0;
      else if (cont_mode && wr_en && last_slot)
        drain_q <= 1'b1;
      if (cont_mode && wr_en && last_slot)
        fills_q <= fills_q + 1'b1;
      if (ack_ok && fills_q == FW'(FILLS))
        cap_done_q <= 1'b1;
    end
  end

  // R6
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(DEPTH));
  // R8
  drain_full_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(drain_q) |-> count_q == CW'(DEPTH));
  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (drain_q && !drain_ack) |=> ($stable(count_q) && $stable(wptr_q)));
  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (drain_q && drain_ack && cont_mode) |=> (!drain_q && count_q == '0));
  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cap_done_q |=> cap_done_q);
  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cap_done_q |-> !drain_q);
endmodule

// File: rtl/brtrace_mem.sv
`timescale 1ns/1ps
module brtrace_mem #(
  parameter int DEPTH = 8,
  parameter int DW    = 66,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      ram[waddr] <= wdata;
    rdata <= ram[raddr];
  end
endmodule

// File: rtl/brtrace_buf.sv
`timescale 1ns/1ps
module brtrace_buf #(
  parameter int AW    = 32,
  parameter int DEPTH = 8,
  parameter int FILLS = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int DW = 2 + 2 * AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          br_valid,
  input  logic [1:0]    br_class,
  input  logic [AW-1:0] br_src,
  input  logic [AW-1:0] br_dst,
  input  logic [AW-1:0] br_next_pc,
  input  logic          br_zero_disp,
  input  logic          br_from_reset,
  input  logic          br_completion,
  input  logic          en_normal,
  input  logic          en_subr,
  input  logic          en_excp,
  input  logic          cont_mode,
  input  logic          drain_ack,
  input  logic [PW-1:0] rd_idx,
  output logic [AW-1:0] rd_src,
  output logic [AW-1:0] rd_dst,
  output logic [1:0]    rd_class,
  output logic [CW-1:0] fill_cnt,
  output logic          drain_req,
  output logic          cap_done
);
  logic          keep, wr_en;
  logic [AW-1:0] src_sel;
  logic [PW-1:0] wptr, raddr;
  logic [DW-1:0] rdata;

  brtrace_filter #(.AW(AW)) u_filter (
    .br_valid(br_valid), .br_class(br_class), .br_src(br_src),
    .br_next_pc(br_next_pc), .br_zero_disp(br_zero_disp),
    .br_from_reset(br_from_reset), .br_completion(br_completion),
    .en_normal(en_normal), .en_subr(en_subr), .en_excp(en_excp),
    .keep(keep), .src_sel(src_sel)
  );

  brtrace_ctrl #(.DEPTH(DEPTH), .FILLS(FILLS)) u_ctrl (
    .clk(clk), .rst(rst), .keep(keep), .cont_mode(cont_mode),
    .drain_ack(drain_ack), .wr_en(wr_en), .wptr_q(wptr),
    .count_q(fill_cnt), .drain_q(drain_req), .cap_done_q(cap_done)
  );

  // oldest entry sits count places behind the write pointer
  assign raddr = wptr - fill_cnt[PW-1:0] + rd_idx;

  brtrace_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk(clk), .we(wr_en), .waddr(wptr),
    .wdata({br_class, src_sel, br_dst}),
    .raddr(raddr), .rdata(rdata)
  );

  assign {rd_class, rd_src, rd_dst} = rdata;
endmodule

// File: tb/brtrace_buf_tb.sv
`timescale 1ns/1ps
module brtrace_buf_tb;
  localparam int AW = 32;
  localparam int DW = 2 + 2 * AW;

  logic clk = 0, rst = 1;
  logic br_valid = 0, br_zero_disp = 0, br_from_reset = 0, br_completion = 0;
  logic [1:0] br_class = 0;
  logic [AW-1:0] br_src = 0, br_dst = 0, br_next_pc = 0;
  logic en_normal = 1, en_subr = 1, en_excp = 1, cont_mode = 0, drain_ack = 0;
  logic [2:0] rd_idx = 0;
  logic [AW-1:0] rd_src, rd_dst;
  logic [1:0] rd_class;
  logic [3:0] fill_cnt;
  logic drain_req, cap_done;

  int n_chk = 0, n_bad = 0;
  bit reported = 0;

  logic [DW-1:0] mq[$];
  bit m_drain = 0, m_done = 0;
  int m_fills = 0;

  always #2 clk = ~clk;

  brtrace_buf #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .br_valid(br_valid), .br_class(br_class),
    .br_src(br_src), .br_dst(br_dst), .br_next_pc(br_next_pc),
    .br_zero_disp(br_zero_disp), .br_from_reset(br_from_reset),
    .br_completion(br_completion), .en_normal(en_normal), .en_subr(en_subr),
    .en_excp(en_excp), .cont_mode(cont_mode), .drain_ack(drain_ack),
    .rd_idx(rd_idx), .rd_src(rd_src), .rd_dst(rd_dst), .rd_class(rd_class),
    .fill_cnt(fill_cnt), .drain_req(drain_req), .cap_done(cap_done)
  );

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference, stepped on each rising edge
  always @(posedge clk) begin
    bit en, take, hold;
    logic [AW-1:0] s;
    if (rst) begin
      mq.delete(); m_drain = 0; m_done = 0; m_fills = 0;
    end else begin
      en = (br_class == 0 && en_normal) || (br_class == 1 && en_subr) ||
           (br_class == 2 && en_excp);
      take = br_valid && en && !br_zero_disp && !br_from_reset;
      hold = cont_mode && (m_drain || m_done);
      s = (br_class == 2 && br_completion) ? br_next_pc : br_src;
      if (cont_mode && m_drain && drain_ack) begin
        mq.delete(); m_drain = 0;
        if (m_fills == 4) m_done = 1;
      end else if (take && !hold) begin
        mq.push_back({br_class, s, br_dst});
        if (cont_mode) begin
          if (mq.size() == 8) begin m_drain = 1; m_fills++; end
        end else if (mq.size() > 8) begin
          void'(mq.pop_front());
        end
      end
    end
  end

  // status compare every falling edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R6 fill_cnt", DW'(fill_cnt), DW'(mq.size()));
      chk("R8 drain_req", DW'(drain_req), DW'(m_drain));
      chk("R10 cap_done", DW'(cap_done), DW'(m_done));
    end
  end

  task automatic send(logic [1:0] c, logic [AW-1:0] s, logic [AW-1:0] d,
                      bit zd = 0, bit rf = 0, bit cmp = 0, logic [AW-1:0] np = 0);
    @(negedge clk);
    br_valid = 1; br_class = c; br_src = s; br_dst = d;
    br_zero_disp = zd; br_from_reset = rf; br_completion = cmp; br_next_pc = np;
    @(negedge clk);
    br_valid = 0; br_zero_disp = 0; br_from_reset = 0; br_completion = 0;
  endtask

  task automatic rd_chk(string tag, int k);
    @(negedge clk);
    rd_idx = 3'(k);
    @(negedge clk);
    chk(tag, {rd_class, rd_src, rd_dst}, mq[k]);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic ack();
    @(negedge clk); drain_ack = 1;
    @(negedge clk); drain_ack = 0;
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    do_reset();
    // R1
    chk("R1 fill_cnt", DW'(fill_cnt), 0);
    chk("R1 drain_req", DW'(drain_req), 0);
    chk("R1 cap_done", DW'(cap_done), 0);

    // wrap mode, mixed classes (R6, R7)
    send(0, 32'h1000, 32'h2000);
    send(1, 32'h1100, 32'h2100);
    send(2, 32'h1200, 32'h2200);
    for (int k = 0; k < 3; k++) rd_chk("R7 read", k);

    // R2: disabled class and code 3 are dropped
    en_subr = 0;
    send(1, 32'hBAD0, 32'hBAD1);
    send(3, 32'hBAD2, 32'hBAD3);
    chk("R2 fill_cnt", DW'(fill_cnt), 3);
    en_subr = 1;
    send(1, 32'h1300, 32'h2300);
    chk("R2 fill_cnt", DW'(fill_cnt), 4);

    // R3, R4
    send(0, 32'hBAD4, 32'hBAD5, 1);
    chk("R3 fill_cnt", DW'(fill_cnt), 4);
    send(2, 32'hBAD6, 32'hA0000000, 0, 1);
    chk("R4 fill_cnt", DW'(fill_cnt), 4);
    rd_chk("R4 newest", 3);

    // R5
    send(2, 32'h1400, 32'h2400, 0, 0, 1, 32'h1402);
    rd_chk("R5 completion src", 4);
    chk("R5 src", DW'(rd_src), DW'(32'h1402));
    send(0, 32'h1500, 32'h2500, 0, 0, 1, 32'h1502);
    rd_chk("R5 normal ignores flag", 5);
    chk("R5 src", DW'(rd_src), DW'(32'h1500));

    // R6 overflow
    for (int k = 0; k < 9; k++) send(2'(k % 3), 32'h3000 + k, 32'h4000 + k);
    chk("R6 saturate", DW'(fill_cnt), 8);
    for (int k = 0; k < 8; k++) rd_chk("R6 oldest-first", k);

    // continuous mode
    cont_mode = 1;
    do_reset();
    for (int f = 0; f < 4; f++) begin
      for (int k = 0; k < 8; k++) send(2'(k % 3), 32'h5000 + 16 * f + k, 32'h6000 + k);
      chk("R8 drain raised", DW'(drain_req), 1);
      send(0, 32'hDEAD, 32'hBEEF);
      chk("R8 held", DW'(fill_cnt), 8);
      rd_chk("R8 first", 0);
      rd_chk("R8 last", 7);
      ack();
      chk("R9 cleared", DW'(drain_req), 0);
      chk("R9 emptied", DW'(fill_cnt), 0);
    end
    chk("R10 done", DW'(cap_done), 1);
    send(0, 32'h7000, 32'h7001);
    chk("R10 no store", DW'(fill_cnt), 0);
    chk("R10 no drain", DW'(drain_req), 0);
    report();
  end
endmodule